// File: doc/BRIEF.md
# Sprite DMA Channel Controller

This block runs one hardware sprite's DMA channel. It keeps its own copies of the sprite's position and control words and derives a vertical start line and a vertical stop line from them. At the start of every line it compares the beam's line number with both values and sets or clears a DMA flip-flop. Within each line the channel owns two fetch slots. In each slot it decides whether to read a control word, read a data word or do nothing. Every word it reads moves its word pointer forward by one.

The beam counters, the global sprite enable and a PAL/NTSC select come from the surrounding video timing logic. The CPU side writes the position word, the control word and the pointer through dedicated strobes. Memory reads are issued as a one-cycle request with a word address, and the memory returns the word in the same cycle. The two data latches and an armed flag go to the display serialiser, which is outside this block.

Top module: `sprite_dma_chan`

## Requirements
- R1: After reset, no request is issued, the pointer is 0, the position and control copies and both data latches are 0, and armed is low.
- R2: The start line is {control[2], position[15:8]} and the stop line is {control[1], control[15:8]}. A CPU write and a DMA fetch of the same word change the copies and the decoded lines in the same way.
- R3: When hpos is 0, a stop line equal to vpos clears the DMA flip-flop, and otherwise a start line equal to vpos sets it. If both match, stop wins. This runs whatever the sprite enable is doing.
- R4: Requests occur only at hpos 0x15+4N (slot A) and hpos 0x17+4N (slot B), where N is CHAN_ID. addr_o carries the current pointer.
- R5: On the stop line, slot A fetches the position word and slot B fetches the control word. On any other line with the flip-flop set, slot A fetches data word A and slot B fetches data word B.
- R6: Each slot checks spr_en_i only in its own cycle, so an enable edge between the two slots yields exactly one fetch.
- R7: The pointer goes up by one for each word fetched and stays put on a skipped slot. A CPU pointer write loads it and takes precedence over a fetch increment.
- R8: At the start of the blanking line (0x19 with pal_i high, 0x14 with it low), the stop line is forced to that line, which makes both slots fetch control words. No request is issued on any line numbered below it.
- R9: An all-zero position/control pair decodes to start = stop = 0, and the channel issues no request until the next blanking line.
- R10: A data A fetch sets armed. A control fetch or a CPU control write clears it. While DMA is off, the latches and armed keep their values.
- R11: A position or control update whose new start or stop equals the current vpos re-runs the comparison in the same cycle, so the rest of that line's slots follow the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one colour clock per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pal_i | input | 1 | 1 selects the PAL blanking line, 0 the NTSC one |
| spr_en_i | input | 1 | Global sprite DMA enable |
| vpos_i | input | 9 | Beam line number |
| hpos_i | input | HPOS_W | Beam colour-clock position in the line |
| pos_we_i | input | 1 | CPU write strobe for the position word |
| ctl_we_i | input | 1 | CPU write strobe for the control word |
| ptr_we_i | input | 1 | CPU write strobe for the pointer |
| wdata_i | input | 16 | CPU write data for position or control |
| ptr_wdata_i | input | PTR_W | CPU write data for the pointer |
| rdata_i | input | 16 | Memory word returned in the request cycle |
| req_o | output | 1 | Memory read request |
| addr_o | output | PTR_W | Word address of the request |
| pos_o | output | 16 | Local position word copy |
| ctl_o | output | 16 | Local control word copy |
| vstart_o | output | 9 | Decoded start line |
| vstop_o | output | 9 | Decoded, or forced, stop line |
| data_a_o | output | 16 | Data latch A |
| data_b_o | output | 16 | Data latch B |
| armed_o | output | 1 | Sprite armed for display |

## Verification
A wrong flip-flop or stop-line flag shows up within the same line, as a request missing or extra at hpos 0x15+4N or 0x17+4N, or as a control fetch where a data fetch belongs. A pointer fault shows on addr_o at the next request. Its cumulative effect is visible after any run of lines with skipped slots. Decode or forcing errors appear on vstart_o and vstop_o one cycle after the write, fetch or blanking line start that caused them. A latch or armed fault shows directly on the display-side outputs after the slot concerned.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;
  localparam int VPOS_W = 9;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    FETCH_NONE,
    FETCH_POS,
    FETCH_CTL,
    FETCH_DATA,
    FETCH_DATB
  } fetch_kind_e;

  function automatic logic [VPOS_W-1:0] decode_start(input logic [WORD_W-1:0] pos,
                                                      input logic [WORD_W-1:0] ctl);
    return {ctl[2], pos[15:8]};
  endfunction

  function automatic logic [VPOS_W-1:0] decode_stop(input logic [WORD_W-1:0] ctl);
    return {ctl[1], ctl[15:8]};
  endfunction
endpackage

// File: rtl/sprite_vcompare.sv
module sprite_vcompare
  import sprite_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPOS_W-1:0] vpos_i,
  input  logic              line_start_i,
  input  logic              blank_i,
  input  logic              start_upd_i,
  input  logic [VPOS_W-1:0] start_new_i,
  input  logic              stop_upd_i,
  input  logic [VPOS_W-1:0] stop_new_i,
  output logic [VPOS_W-1:0] start_o,
  output logic [VPOS_W-1:0] stop_o,
  output logic              dma_on_o,
  output logic              stop_line_o
);
  logic [VPOS_W-1:0] start_q, stop_q, start_n, stop_n;
  logic ff_q, ff_n, sl_q, sl_n;
  logic eval, hit_start, hit_stop;

  always_comb begin
    start_n = start_upd_i ? start_new_i : start_q;
    if (line_start_i && blank_i) stop_n = vpos_i;
    else if (stop_upd_i)         stop_n = stop_new_i;
    else                         stop_n = stop_q;
    eval      = line_start_i | start_upd_i | stop_upd_i;
    hit_stop  = (vpos_i == stop_n);
    hit_start = (vpos_i == start_n);
    ff_n = ff_q;
    sl_n = sl_q;
    if (eval) begin
      sl_n = hit_stop;
      if (hit_stop)       ff_n = 1'b0;
      else if (hit_start) ff_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      stop_q  <= '0;
      ff_q    <= 1'b0;
      sl_q    <= 1'b0;
    end else begin
      start_q <= start_n;
      stop_q  <= stop_n;
      ff_q    <= ff_n;
      sl_q    <= sl_n;
    end
  end

  assign start_o     = start_q;
  assign stop_o      = stop_q;
  assign dma_on_o    = ff_q;
  assign stop_line_o = sl_q;

  // R3: stop match at line start clears DMA regardless of enable
  a_r3_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !start_upd_i && !stop_upd_i && !blank_i && vpos_i == stop_q)
    |=> !ff_q);

  // R8: blanking line start forces the stop line and the control fetch
  a_r8_blank_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && blank_i && !stop_upd_i) |=> (sl_q && stop_q == $past(vpos_i)));
endmodule

// File: rtl/sprite_slot_sched.sv
module sprite_slot_sched
  import sprite_dma_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int HPOS_W  = 8
) (
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic              below_blank_i,
  input  logic              en_i,
  input  logic              dma_on_i,
  input  logic              stop_line_i,
  output fetch_kind_e       kind_o
);
  localparam logic [HPOS_W-1:0] SLOT_A = HPOS_W'(8'h15 + 4 * CHAN_ID);
  localparam logic [HPOS_W-1:0] SLOT_B = HPOS_W'(8'h17 + 4 * CHAN_ID);

  logic at_a, at_b;

  always_comb begin
    at_a   = (hpos_i == SLOT_A);
    at_b   = (hpos_i == SLOT_B);
    kind_o = FETCH_NONE;
    if (en_i && !below_blank_i && (at_a || at_b)) begin
      if (stop_line_i)   kind_o = at_a ? FETCH_POS  : FETCH_CTL;
      else if (dma_on_i) kind_o = at_a ? FETCH_DATA : FETCH_DATB;
    end
  end
endmodule

// File: rtl/sprite_data_latch.sv
module sprite_data_latch
  import sprite_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_a_i,
  input  logic              load_b_i,
  input  logic              disarm_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_a_o,
  output logic [WORD_W-1:0] data_b_o,
  output logic              armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_a_o <= '0;
      data_b_o <= '0;
      armed_o  <= 1'b0;
    end else begin
      if (load_a_i) data_a_o <= data_i;
      if (load_b_i) data_b_o <= data_i;
      if (disarm_i)      armed_o <= 1'b0;
      else if (load_a_i) armed_o <= 1'b1;
    end
  end

  // R10: control fetch or write always leaves the sprite disarmed
  a_r10_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> !armed_o);

  // R10: only a data A load may raise armed
  a_r10_arm_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_a_i) |=> !$rose(armed_o));
endmodule

// File: rtl/sprite_dma_chan.sv
module sprite_dma_chan
  import sprite_dma_pkg::*;
#(
  parameter int                CHAN_ID    = 0,
  parameter int                HPOS_W     = 8,
  parameter int                PTR_W      = 19,
  parameter logic [VPOS_W-1:0] PAL_BLANK  = 9'h019,
  parameter logic [VPOS_W-1:0] NTSC_BLANK = 9'h014
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pal_i,
  input  logic              spr_en_i,
  input  logic [VPOS_W-1:0] vpos_i,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic              pos_we_i,
  input  logic              ctl_we_i,
  input  logic              ptr_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  ptr_wdata_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              req_o,
  output logic [PTR_W-1:0]  addr_o,
  output logic [WORD_W-1:0] pos_o,
  output logic [WORD_W-1:0] ctl_o,
  output logic [VPOS_W-1:0] vstart_o,
  output logic [VPOS_W-1:0] vstop_o,
  output logic [WORD_W-1:0] data_a_o,
  output logic [WORD_W-1:0] data_b_o,
  output logic              armed_o
);
  localparam logic [HPOS_W-1:0] SLOT_A = HPOS_W'(8'h15 + 4 * CHAN_ID);
  localparam logic [HPOS_W-1:0] SLOT_B = HPOS_W'(8'h17 + 4 * CHAN_ID);

  logic [VPOS_W-1:0] blank_line;
  logic              line_start, below_blank, dma_on, stop_line;
  fetch_kind_e       kind;
  logic              pos_upd, ctl_upd;
  logic [WORD_W-1:0] pos_q, ctl_q, pos_eff, ctl_eff;
  logic [PTR_W-1:0]  ptr_q;

  assign blank_line  = pal_i ? PAL_BLANK : NTSC_BLANK;
  assign line_start  = (hpos_i == '0);
  assign below_blank = (vpos_i < blank_line);

  sprite_slot_sched #(.CHAN_ID(CHAN_ID), .HPOS_W(HPOS_W)) i_sched (
    .hpos_i       (hpos_i),
    .below_blank_i(below_blank),
    .en_i         (spr_en_i),
    .dma_on_i     (dma_on),
    .stop_line_i  (stop_line),
    .kind_o       (kind)
  );

  // DMA fetch has precedence over a same-cycle CPU write of the same word
  always_comb begin
    pos_upd = pos_we_i || (kind == FETCH_POS);
    ctl_upd = ctl_we_i || (kind == FETCH_CTL);
    pos_eff = pos_q;
    ctl_eff = ctl_q;
    if (kind == FETCH_POS) pos_eff = rdata_i;
    else if (pos_we_i)     pos_eff = wdata_i;
    if (kind == FETCH_CTL) ctl_eff = rdata_i;
    else if (ctl_we_i)     ctl_eff = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      ctl_q <= '0;
      ptr_q <= '0;
    end else begin
      pos_q <= pos_eff;
      ctl_q <= ctl_eff;
      if (ptr_we_i)                ptr_q <= ptr_wdata_i;
      else if (kind != FETCH_NONE) ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  sprite_vcompare i_vcmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vpos_i      (vpos_i),
    .line_start_i(line_start),
    .blank_i     (vpos_i == blank_line),
    .start_upd_i (pos_upd || ctl_upd),
    .start_new_i (decode_start(pos_eff, ctl_eff)),
    .stop_upd_i  (ctl_upd),
    .stop_new_i  (decode_stop(ctl_eff)),
    .start_o     (vstart_o),
    .stop_o      (vstop_o),
    .dma_on_o    (dma_on),
    .stop_line_o (stop_line)
  );

  sprite_data_latch i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_a_i(kind == FETCH_DATA),
    .load_b_i(kind == FETCH_DATB),
    .disarm_i(ctl_upd),
    .data_i  (rdata_i),
    .data_a_o(data_a_o),
    .data_b_o(data_b_o),
    .armed_o (armed_o)
  );

  assign req_o  = (kind != FETCH_NONE);
  assign addr_o = ptr_q;
  assign pos_o  = pos_q;
  assign ctl_o  = ctl_q;

  a_r4_slot_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (hpos_i == SLOT_A || hpos_i == SLOT_B));

  a_r6_enable_sampled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> spr_en_i);

  a_r8_no_fetch_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vpos_i >= blank_line));

  a_r7_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !ptr_we_i) |=> $stable(addr_o));

  a_r7_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ptr_we_i) |=> (addr_o == $past(addr_o) + PTR_W'(1)));
endmodule

// File: tb/test_sprite_dma_chan.sv
module test_sprite_dma_chan;
  localparam int PTR_W = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pal = 1'b1;
  logic        en = 1'b0;
  logic [8:0]  vpos = '0;
  logic [7:0]  hpos = 8'h05;
  logic        pos_we = 1'b0, ctl_we = 1'b0, ptr_we = 1'b0;
  logic [15:0] wdata = '0;
  logic [PTR_W-1:0] ptr_wdata = '0;
  logic [15:0] rdata;
  logic        req;
  logic [PTR_W-1:0] addr;
  logic [15:0] pos_w, ctl_w, data_a, data_b;
  logic [8:0]  vstart, vstop;
  logic        armed;

  logic [15:0] mem [0:255];
  assign rdata = mem[addr[7:0]];

  int total = 0, bad = 0;
  int line_reqs;
  logic [PTR_W-1:0] r_addr [0:1];
  int r_h [0:1];
  bit done = 0;

  always #4 clk = ~clk;

  sprite_dma_chan i_sprite_dma_chan (
    .clk_i(clk), .rst_ni(rst_n), .pal_i(pal), .spr_en_i(en),
    .vpos_i(vpos), .hpos_i(hpos),
    .pos_we_i(pos_we), .ctl_we_i(ctl_we), .ptr_we_i(ptr_we),
    .wdata_i(wdata), .ptr_wdata_i(ptr_wdata), .rdata_i(rdata),
    .req_o(req), .addr_o(addr), .pos_o(pos_w), .ctl_o(ctl_w),
    .vstart_o(vstart), .vstop_o(vstop),
    .data_a_o(data_a), .data_b_o(data_b), .armed_o(armed)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_from(input logic [8:0] v, input int h0, input bit en_a, input bit en_b);
    line_reqs = 0;
    for (int h = h0; h < 32; h++) begin
      @(negedge clk);
      vpos = v;
      hpos = 8'(h);
      en = (h < 'h16) ? en_a : en_b;
      #1;
      if (req) begin
        if (line_reqs < 2) begin
          r_addr[line_reqs] = addr;
          r_h[line_reqs] = h;
        end
        line_reqs++;
      end
    end
  endtask

  task automatic run_line(input logic [8:0] v, input bit en_a, input bit en_b);
    run_from(v, 0, en_a, en_b);
  endtask

  // which: 0 position, 1 control, 2 pointer
  task automatic cpu_wr(input int which, input logic [8:0] v, input logic [31:0] d);
    @(negedge clk);
    vpos = v; hpos = 8'h05; en = 1'b0;
    wdata = d[15:0]; ptr_wdata = PTR_W'(d);
    pos_we = (which == 0); ctl_we = (which == 1); ptr_we = (which == 2);
    @(negedge clk);
    pos_we = 0; ctl_we = 0; ptr_we = 0;
  endtask

  task automatic t_reset();
    check("R1 req", req, 0);
    check("R1 ptr", addr, 0);
    check("R1 armed", armed, 0);
    check("R1 data_a", data_a, 0);
    check("R1 pos/ctl", {pos_w, ctl_w}, 0);
  endtask

  task automatic t_decode_and_inhibit();
    cpu_wr(1, 9'h005, 16'h3006);
    cpu_wr(0, 9'h005, 16'h1000);
    check("R2 cpu start", vstart, 9'h110);
    check("R2 cpu stop", vstop, 9'h130);
    cpu_wr(1, 9'h005, 16'h0A00);
    cpu_wr(0, 9'h005, 16'h0800);
    begin
      int n = 0;
      for (int v = 6; v < 13; v++) begin
        run_line(9'(v), 1, 1);
        n += line_reqs;
      end
      check("R8 no fetch above blank", n, 0);
    end
  endtask

  task automatic t_blank_pal();
    cpu_wr(2, 9'h018, 32'h40);
    run_line(9'h019, 1, 1);
    check("R8 pal blank fetches", line_reqs, 2);
    check("R5 pos then ctl addr", {r_addr[0], r_addr[1]}, {19'h40, 19'h41});
    check("R4 slot cycles", {r_h[0][7:0], r_h[1][7:0]}, 16'h1517);
    check("R2 dma decode", {vstart, vstop}, {9'h020, 9'h023});
    check("R2 dma copies", {pos_w, ctl_w}, 32'h2000_2300);
    check("R7 ptr after ctl", addr, 19'h42);
    begin
      int n = 0;
      for (int v = 'h1A; v < 'h20; v++) begin
        run_line(9'(v), 1, 1);
        n += line_reqs;
      end
      check("R3 idle before start", n, 0);
    end
  endtask

  task automatic t_data_and_enable();
    run_line(9'h020, 1, 1);
    check("R5 data fetch count", line_reqs, 2);
    check("R10 data latches", {data_a, data_b}, {16'hA042, 16'hA043});
    check("R10 armed by data A", armed, 1);
    run_line(9'h021, 1, 0);
    check("R6 enable edge one fetch", line_reqs, 1);
    check("R6 latches", {data_a, data_b}, {16'hA044, 16'hA043});
    check("R7 ptr one step", addr, 19'h45);
    run_line(9'h022, 0, 1);
    check("R6 second slot only", line_reqs, 1);
    check("R7 stream shifted", {data_a, data_b}, {16'hA044, 16'hA045});
    check("R7 ptr", addr, 19'h46);
  endtask

  task automatic t_stop_while_disabled();
    run_line(9'h023, 0, 0);
    check("R3 stop line with dma off no fetch", line_reqs, 0);
    run_line(9'h024, 1, 1);
    check("R3 comparator ran while off", line_reqs, 0);
    check("R10 stale latches held", {armed, data_a, data_b}, {1'b1, 16'hA044, 16'hA045});
    check("R7 ptr parked", addr, 19'h46);
  endtask

  task automatic t_reeval_and_terminator();
    cpu_wr(1, 9'h02F, 16'h3200);
    check("R10 ctl write disarms", armed, 0);
    cpu_wr(0, 9'h030, 16'h3000);
    run_from(9'h030, 6, 1, 1);
    check("R11 pos write on matching line", line_reqs, 2);
    check("R11 addresses", {r_addr[0], r_addr[1]}, {19'h46, 19'h47});
    check("R10 armed", armed, 1);
    run_line(9'h031, 1, 1);
    mem[8'h4A] = 16'h0000;
    mem[8'h4B] = 16'h0000;
    run_line(9'h032, 1, 1);
    check("R5 stop line control fetch", {r_addr[0], r_addr[1]}, {19'h4A, 19'h4B});
    check("R10 ctl fetch disarms", armed, 0);
    check("R9 terminator decode", {vstart, vstop}, 18'h0);
    begin
      int n = 0;
      for (int v = 'h33; v < 'h39; v++) begin
        run_line(9'(v), 1, 1);
        n += line_reqs;
      end
      run_line(9'h000, 1, 1);
      n += line_reqs;
      check("R9 terminator silent", n, 0);
    end
  endtask

  task automatic t_ntsc_and_priority();
    pal = 1'b0;
    mem[8'h50] = 16'h1800;
    mem[8'h51] = 16'h1800;
    mem[8'h52] = 16'h0000;
    mem[8'h53] = 16'h0000;
    cpu_wr(2, 9'h013, 32'h50);
    run_line(9'h014, 1, 1);
    check("R8 ntsc blank fetch", line_reqs, 2);
    check("R2 start=stop", {vstart, vstop}, {9'h018, 9'h018});
    run_line(9'h018, 1, 1);
    check("R3 stop wins over start", {r_addr[0], r_addr[1]}, {19'h52, 19'h53});
    check("R3 no arm", armed, 0);
    check("R7 ptr", addr, 19'h54);
    pal = 1'b1;
  endtask

  task automatic t_missed_data();
    cpu_wr(1, 9'h060, 16'h6200);
    cpu_wr(0, 9'h060, 16'h6000);
    run_from(9'h060, 6, 0, 1);
    check("R6 only DATB", line_reqs, 1);
    check("R10 missed data A stays disarmed", armed, 0);
    check("R10 data B latched", data_b, 16'hA054);
    cpu_wr(1, 9'h061, 16'h6100);
    run_from(9'h061, 6, 1, 1);
    check("R11 ctl write makes stop line", {r_addr[0], r_addr[1]}, {19'h55, 19'h56});
    check("R2 fetched ctl copy", ctl_w, 16'hA056);
    check("R2 fetched decode", {vstart, vstop}, {9'h1A0, 9'h1A0});
    check("R7 ptr", addr, 19'h57);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
    mem[8'h40] = 16'h2000;
    mem[8'h41] = 16'h2300;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode_and_inhibit();
    t_blank_pal();
    t_data_and_enable();
    t_stop_while_disabled();
    t_reeval_and_terminator();
    t_ntsc_and_priority();
    t_missed_data();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule